// File: doc/BRIEF.md
# Module Control and Reset-Pulse Register

This block sits behind a 16-bit host register bus. It holds two registers. The first is a read/write control register that carries four geographic-address override bits, a guarded clock-source select, a protection-mode bit and four optical transmitter disable bits. The second is a write-triggered reset register. Writing ones to it launches reset actions. The control register is restored and its override bits are reloaded, timed active-low pulses go to an external timing receiver and to a configuration controller, and single-cycle strobes go to local serial-bus controllers and to two optical module groups.

The host selects a register with `host_addr` (0 = control, 1 = reset). It writes with a one-cycle `host_wr` and sees the selected register on `host_rdata` combinationally. A `cfg_load` pulse from the configuration logic copies the backplane address pins into the override bits. Pulse lengths come from the `CLK_HZ` parameter and are rounded up to whole clock cycles.

Top module: `modctl_regs`

## Requirements
- R1: After reset the control register reads 0x0030: clock select (bit 4) and protection mode (bit 5) are 1 and every other bit is 0. Both pulse outputs are high, all strobes are low and all transmitter disables are low.
- R2: A `cfg_load` pulse loads control bits 3..0 from `geo_pins` with bit0←pin0, bit1←pin4, bit2←pin5 and bit3←pin6. The other control bits are left unchanged.
- R3: A control write with bit 4 = 1 leaves the clock select unchanged while `rx_ready` is low. A write of 0 to bit 4 always takes effect, and a write of 1 takes effect while `rx_ready` is high.
- R4: Control bits 11..6 always read 0 and writes to them have no effect. Bits 15..12, 5 and 3..0 read back the last value written, so a read returns the written value ANDed with 0xF03F when `rx_ready` is high.
- R5: `tx_disable[3:0]` equals control bits 15..12, and `clk_sel_rx` and `prot_mode` equal bits 4 and 5.
- R6: The reset register always reads 0. Writing 0 to it changes neither the control register nor any output.
- R7: Writing 1 to reset bit 1 drives `rx_rst_n` low for ceil(500 ns × CLK_HZ) cycles (20 at 40 MHz), starting the cycle after the write. A new trigger during the pulse restarts the full length.
- R8: Writing 1 to reset bit 3 drives `cfg_rst_n` low for ceil(1500 ns × CLK_HZ) cycles (60 at 40 MHz), starting the cycle after the write. It has the same restart rule.
- R9: Writing 1 to reset bit 0 returns the control register to its reset values, with bits 3..0 reloaded from `geo_pins` as in R2. It drives no external reset.
- R10: Reset bits 2, 9, 11, 12, 13, 14 and 15 drive `bus_rst[0]` to `bus_rst[6]` in that order, each high for exactly the one cycle after the write.
- R11: Reset bits 8 and 10 drive `optics_rst[0]` and `optics_rst[1]`, each high for exactly the one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| host_wr | input | 1 | Write strobe for the addressed register |
| host_addr | input | 1 | Register select: 0 = control, 1 = reset |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data of the addressed register |
| cfg_load | input | 1 | Load the override bits from the address pins |
| geo_pins | input | 7 | Backplane geographic address pins |
| rx_ready | input | 1 | Timing receiver ready |
| geo_override | output | 4 | Control bits 3..0 |
| clk_sel_rx | output | 1 | 1 selects the receiver clock, 0 selects the crystal |
| prot_mode | output | 1 | Protection-mode select |
| tx_disable | output | 4 | Optical transmitter disables |
| rx_rst_n | output | 1 | Timed active-low timing-receiver reset |
| cfg_rst_n | output | 1 | Timed active-low configuration-controller reset |
| bus_rst | output | 7 | One-cycle serial-bus controller reset strobes |
| optics_rst | output | 2 | One-cycle optical module group resets |

## Verification
A corrupted control field appears on the same-named output and on a read of address 0 in the cycle after the write that set it. The bench therefore compares both after every write across a dense sweep of data patterns and all 128 pin patterns. A timer that counts wrong shows up as a pulse edge one cycle early or late, so each pulse is sampled every cycle from the trigger to its release, including after a restart. A mis-wired or held strobe shows in the first cycle after a reset write, or as a strobe still high one cycle later.

// File: rtl/modctl_regs.sv
`timescale 1ns/1ps
module modctl_regs #(
  parameter int unsigned CLK_HZ     = 40_000_000,
  parameter int unsigned RX_RST_NS  = 500,
  parameter int unsigned CFG_RST_NS = 1500
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic        host_addr,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  input  logic        cfg_load,
  input  logic [6:0]  geo_pins,
  input  logic        rx_ready,
  output logic [3:0]  geo_override,
  output logic        clk_sel_rx,
  output logic        prot_mode,
  output logic [3:0]  tx_disable,
  output logic        rx_rst_n,
  output logic        cfg_rst_n,
  output logic [6:0]  bus_rst,
  output logic [1:0]  optics_rst
);
  localparam logic [63:0] NS_PER_S = 64'd1_000_000_000;
  localparam int unsigned RX_CYC  = 32'((64'(RX_RST_NS)  * 64'(CLK_HZ) + NS_PER_S - 64'd1) / NS_PER_S);
  localparam int unsigned CFG_CYC = 32'((64'(CFG_RST_NS) * 64'(CLK_HZ) + NS_PER_S - 64'd1) / NS_PER_S);
  localparam int RX_W  = $clog2(RX_CYC + 1);
  localparam int CFG_W = $clog2(CFG_CYC + 1);

  logic wr_ctrl, wr_rst, mod_rst;
  logic [3:0] geo_map;
  logic [RX_W-1:0]  rx_cnt;
  logic [CFG_W-1:0] cfg_cnt;

  assign wr_ctrl = host_wr & ~host_addr;
  assign wr_rst  = host_wr &  host_addr;
  assign mod_rst = wr_rst & host_wdata[0];
  assign geo_map = {geo_pins[6], geo_pins[5], geo_pins[4], geo_pins[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      geo_override <= '0;
      clk_sel_rx   <= 1'b1;
      prot_mode    <= 1'b1;
      tx_disable   <= '0;
    end else if (mod_rst) begin
      geo_override <= geo_map;
      clk_sel_rx   <= 1'b1;
      prot_mode    <= 1'b1;
      tx_disable   <= '0;
    end else begin
      if (cfg_load)     geo_override <= geo_map;
      else if (wr_ctrl) geo_override <= host_wdata[3:0];
      if (wr_ctrl) begin
        prot_mode  <= host_wdata[5];
        tx_disable <= host_wdata[15:12];
        if (!host_wdata[4] || rx_ready) clk_sel_rx <= host_wdata[4];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_cnt     <= '0;
      cfg_cnt    <= '0;
      bus_rst    <= '0;
      optics_rst <= '0;
    end else begin
      if (wr_rst && host_wdata[1]) rx_cnt <= RX_W'(RX_CYC);
      else if (rx_cnt != '0)       rx_cnt <= rx_cnt - 1'b1;
      if (wr_rst && host_wdata[3]) cfg_cnt <= CFG_W'(CFG_CYC);
      else if (cfg_cnt != '0)      cfg_cnt <= cfg_cnt - 1'b1;
      bus_rst    <= wr_rst ? {host_wdata[15:11], host_wdata[9], host_wdata[2]} : 7'd0;
      optics_rst <= wr_rst ? {host_wdata[10], host_wdata[8]} : 2'd0;
    end
  end

  assign rx_rst_n  = (rx_cnt == '0);
  assign cfg_rst_n = (cfg_cnt == '0);
  assign host_rdata = host_addr ? 16'h0000
                    : {tx_disable, 6'b0, prot_mode, clk_sel_rx, geo_override};

  p_clksel_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_sel_rx && !rx_ready && !mod_rst) |=> !clk_sel_rx);
  p_txdis_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ctrl && !mod_rst) |=> $stable(tx_disable));
  p_rx_pulse_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_rst_n) |-> $past(wr_rst && host_wdata[1]));
  p_cfg_pulse_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_rst_n) |-> $past(wr_rst && host_wdata[3]));
  p_bus_strobe_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst[0] |-> $past(wr_rst && host_wdata[2]));
  p_optics_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    optics_rst[1] |-> $past(wr_rst && host_wdata[10]));
endmodule

// File: tb/test_modctl_regs.sv
`timescale 1ns/1ps
module test_modctl_regs;
  logic clk = 0, rst_n = 0, host_wr = 0, host_addr = 0, cfg_load = 0, rx_ready = 0;
  logic [15:0] host_wdata = 0, host_rdata;
  logic [6:0] geo_pins = 0;
  logic [3:0] geo_override, tx_disable;
  logic clk_sel_rx, prot_mode, rx_rst_n, cfg_rst_n;
  logic [6:0] bus_rst;
  logic [1:0] optics_rst;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  modctl_regs #(.CLK_HZ(40_000_000)) i_modctl_regs (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [15:0] d);
    @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 0; host_wdata = 0;
  endtask

  task automatic rd_ctrl(string req, logic [15:0] exp);
    host_addr = 0; #1; chk(req, host_rdata, exp);
  endtask

  function automatic logic [6:0] bus_exp(logic [15:0] d);
    return {d[15:11], d[9], d[2]};
  endfunction

  task automatic pulse_chk(string req, bit is_rx, int len);
    for (int k = 0; k < len; k++) begin
      chk(req, is_rx ? rx_rst_n : cfg_rst_n, 0);
      @(negedge clk);
    end
    chk(req, is_rx ? rx_rst_n : cfg_rst_n, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd_ctrl("R1 ctrl", 16'h0030);
    chk("R1 pulses", {rx_rst_n, cfg_rst_n}, 2'b11);
    chk("R1 strobes", {bus_rst, optics_rst}, 0);
    chk("R1 txdis", tx_disable, 0);

    for (int p = 0; p < 128; p++) begin
      @(negedge clk); geo_pins = 7'(p); cfg_load = 1;
      @(negedge clk); cfg_load = 0;
      rd_ctrl("R2 geo load", {12'h003, geo_pins[6], geo_pins[5], geo_pins[4], geo_pins[0]});
      chk("R2 geo port", geo_override, {geo_pins[6], geo_pins[5], geo_pins[4], geo_pins[0]});
    end

    rx_ready = 0;
    wr(0, 16'h0000); chk("R3 clear", clk_sel_rx, 0);
    wr(0, 16'h0010); chk("R3 blocked", clk_sel_rx, 0); rd_ctrl("R3 blocked rd", 16'h0000);
    rx_ready = 1;
    wr(0, 16'h0010); chk("R3 allowed", clk_sel_rx, 1);
    rx_ready = 0;
    wr(0, 16'h0000); chk("R3 clear no ready", clk_sel_rx, 0);

    rx_ready = 1;
    for (int i = 0; i < 4096; i++) begin
      logic [15:0] v;
      v = 16'(i * 40503);
      wr(0, v);
      rd_ctrl("R4 readback", v & 16'hF03F);
      chk("R5 outputs", {tx_disable, prot_mode, clk_sel_rx, geo_override},
          {v[15:12], v[5], v[4], v[3:0]});
    end

    for (int b = 0; b < 16; b++) begin
      logic [15:0] d;
      d = 16'(1) << b;
      wr(1, d);
      host_addr = 1; #1; chk("R6 reads zero", host_rdata, 0);
      chk("R10 strobe map", bus_rst, bus_exp(d));
      chk("R11 optics map", optics_rst, {d[10], d[8]});
      @(negedge clk);
      chk("R10 single cycle", bus_rst, 0);
      chk("R11 single cycle", optics_rst, 0);
    end
    repeat (70) @(negedge clk);

    wr(0, 16'h9035);
    wr(1, 16'h0000);
    rd_ctrl("R6 zero write ctrl", 16'h9035);
    chk("R6 zero write outs", {rx_rst_n, cfg_rst_n, bus_rst, optics_rst}, 11'h600);

    geo_pins = 7'h21; rx_ready = 0;
    wr(0, 16'hF002);
    wr(1, 16'h0001);
    rd_ctrl("R9 module reset", 16'h0035);
    chk("R9 no ext reset", {rx_rst_n, cfg_rst_n, bus_rst, optics_rst}, 11'h600);
    chk("R9 txdis", tx_disable, 0);

    wr(1, 16'h0002);
    pulse_chk("R7 rx pulse", 1, 20);
    wr(1, 16'h0002);
    repeat (10) @(negedge clk);
    wr(1, 16'h0002);
    chk("R7 cfg idle", cfg_rst_n, 1);
    pulse_chk("R7 rx restart", 1, 20);

    wr(1, 16'h0008);
    pulse_chk("R8 cfg pulse", 0, 60);
    wr(1, 16'h0008);
    repeat (30) @(negedge clk);
    wr(1, 16'h0008);
    pulse_chk("R8 cfg restart", 0, 60);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule